// File: doc/BRIEF.md
# Receive-Queue Prefetching Read Interface

This block sits between a system bus and a receive-buffer core, such as a serial receiver, that stores incoming bytes in an internal queue. The core exposes two read-only registers on a simple internal bus. The first is a status register that holds the number of queued bytes. The second is a data register; reading it pops one entry from the queue. Without help, every system read would first have to cross the internal bus. This block avoids that cost by keeping two shadow copies close to the system side: a count shadow and a held-byte shadow.

A small sequencer keeps reading the core's count. As soon as the queue holds something and no byte is already held, it pops exactly one byte into the held-byte shadow. While that byte waits, the sequencer keeps refreshing the count. When the system consumes the byte, the next poll decides whether to chain to the next byte or to keep polling. The count shown to the system includes the held byte, so each byte is counted exactly once at every moment. Reading the data address with nothing held returns zero and flags an underflow. It has no other effect. The block has no write path.

Top module: `rxq_prefetch_if`

## Requirements
- R1: After reset the response-valid output is low, a status read returns 0 while the core is empty, and a data read reports an underflow.
- R2: Every system read sampled at a rising edge is answered at the very next edge with the valid output high for one cycle; no read is ever stalled.
- R3: While a byte is held, the status seen by the system keeps following the core's count; a byte pushed into the core shows up in the status within 8 cycles.
- R4: Once the core's queue is non-empty and nothing is held, the sequencer pops one byte, and a later system read of the data address (address 1) returns that byte without underflow.
- R5: A system read of the status address (address 0) returns, zero-extended, the core's queue count plus one if a byte is held.
- R6: Bytes reach the system in the order the core received them, across chained fetches, for every fill level up to a full core queue plus the held byte.
- R7: A data read with no byte held returns 0 with the underflow output high for that response only, and it neither pops the core nor changes the reported status.
- R8: The internal data register is read, and so popped, only while no byte is held; the number of pops never exceeds the bytes consumed by the system plus one.
- R9: Status reads have no side effect on the queue, the held byte or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_rd | input | 1 | System read request, one cycle per read |
| sys_addr | input | 1 | System read address: 0 status, 1 data |
| sys_rdata | output | DATA_W | Read response data |
| sys_rvalid | output | 1 | Response valid, one cycle after the request |
| sys_uflow | output | 1 | Response came from a data read with no byte held |
| int_rd | output | 1 | Internal bus read strobe |
| int_addr | output | 1 | Internal register select: 0 count, 1 data (pop) |
| int_rdata | input | DATA_W | Internal read data, returned one cycle after the strobe |

## Verification
The bench fills a model queue to every level from empty to one beyond its depth. It then drains it and compares order, status and pop count against arithmetic expectations. A design that lost track of the held byte would show a status that is one too high or one too low. A design that popped twice would lose bytes, and the pop counter catches this. The bench reads data twice in a row right after a consume. This targets a design that re-served stale data or fetched on an underflow: it would return a nonzero value or pop an extra byte. Bursts of status reads are placed before draining to expose any status read with a side effect.

// File: rtl/rxq_pf_pkg.sv
package rxq_pf_pkg;
  typedef enum logic [1:0] {
    SEQ_STAT_RD,
    SEQ_STAT_CAP,
    SEQ_DATA_RD,
    SEQ_DATA_CAP
  } seq_state_e;

  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/rxq_pf_rst_sync.sv
module rxq_pf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rxq_pf_seq.sv
module rxq_pf_seq
  import rxq_pf_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             held,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             int_rd,
  output logic             int_addr,
  output logic             cap_stat,
  output logic             cap_data
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_STAT_RD:  state_d = SEQ_STAT_CAP;
      SEQ_STAT_CAP: state_d = ((cnt_in != '0) && !held) ? SEQ_DATA_RD : SEQ_STAT_RD;
      SEQ_DATA_RD:  state_d = SEQ_DATA_CAP;
      SEQ_DATA_CAP: state_d = SEQ_STAT_RD;
      default:      state_d = SEQ_STAT_RD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_STAT_RD;
    else        state_q <= state_d;
  end

  assign int_rd   = (state_q == SEQ_STAT_RD) || (state_q == SEQ_DATA_RD);
  assign int_addr = (state_q == SEQ_DATA_RD) ? ADDR_DATA : ADDR_STAT;
  assign cap_stat = (state_q == SEQ_STAT_CAP);
  assign cap_data = (state_q == SEQ_DATA_CAP);

  AST_POP_ONLY_UNHELD: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rd && int_addr == ADDR_DATA) |-> !held) else $error("pop while held"); // R8
  AST_CAPTURE_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_data |-> $past(int_rd && int_addr == ADDR_DATA)) else $error("capture without pop"); // R4
endmodule

// File: rtl/rxq_pf_shadow.sv
module rxq_pf_shadow #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_stat,
  input  logic              cap_data,
  input  logic              consume,
  input  logic [DATA_W-1:0] int_rdata,
  output logic              held,
  output logic [DATA_W-1:0] data_o,
  output logic [STAT_W-1:0] stat_o
);
  logic [DATA_W-1:0] data_q;
  logic              held_q, held_d;
  logic [CNT_W-1:0]  raw_q, raw_d;
  logic              raw_en, data_en;

  always_comb begin
    held_d = held_q;
    raw_d  = raw_q;
    raw_en = cap_stat || cap_data;
    data_en = cap_data;
    if (cap_stat) raw_d = int_rdata[CNT_W-1:0];
    if (cap_data) begin
      raw_d  = raw_q - CNT_W'(1);
      held_d = 1'b1;
    end
    if (consume) held_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      raw_q  <= '0;
      data_q <= '0;
    end else begin
      held_q <= held_d;
      if (raw_en)  raw_q  <= raw_d;
      if (data_en) data_q <= int_rdata;
    end
  end

  assign held   = held_q;
  assign data_o = data_q;
  assign stat_o = STAT_W'(raw_q) + STAT_W'(held_q);

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_data |-> !held_q) else $error("held byte overwritten"); // R8
  AST_CONSUME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> held_q) else $error("consume with nothing held"); // R7
  AST_HELD_AFTER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_data |=> held_q) else $error("capture did not set held"); // R4
endmodule

// File: rtl/rxq_pf_ctrl.sv
module rxq_pf_ctrl
  import rxq_pf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rd,
  input  logic              sys_addr,
  input  logic              held,
  input  logic [DATA_W-1:0] data_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              consume,
  output logic [DATA_W-1:0] sys_rdata,
  output logic              sys_rvalid,
  output logic              sys_uflow
);
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q, uflow_q, uflow_d;
  logic              rd_data;

  assign rd_data = sys_rd && (sys_addr == ADDR_DATA);
  assign consume = rd_data && held;

  always_comb begin
    rdata_d = '0;
    uflow_d = 1'b0;
    if (sys_addr == ADDR_STAT) rdata_d = DATA_W'(stat_i);
    else if (held)             rdata_d = data_i;
    else                       uflow_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      uflow_q  <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= sys_rd;
      uflow_q  <= sys_rd && uflow_d;
      if (sys_rd) rdata_q <= rdata_d;
    end
  end

  assign sys_rdata  = rdata_q;
  assign sys_rvalid = rvalid_q;
  assign sys_uflow  = uflow_q;

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rd |=> sys_rvalid) else $error("read not answered"); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rd |=> !sys_rvalid) else $error("spurious valid"); // R2
  AST_UFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sys_uflow |-> (sys_rvalid && sys_rdata == '0)) else $error("underflow data"); // R7
  AST_UFLOW_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !held) |=> sys_uflow) else $error("underflow missing"); // R7
endmodule

// File: rtl/rxq_prefetch_if.sv
module rxq_prefetch_if #(
  parameter int DATA_W = 8,
  parameter int QDEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rd,
  input  logic              sys_addr,
  output logic [DATA_W-1:0] sys_rdata,
  output logic              sys_rvalid,
  output logic              sys_uflow,
  output logic              int_rd,
  output logic              int_addr,
  input  logic [DATA_W-1:0] int_rdata
);
  localparam int CNT_W  = $clog2(QDEPTH + 1);
  localparam int STAT_W = $clog2(QDEPTH + 2);

  logic              rst_n_s;
  logic              held, consume, cap_stat, cap_data;
  logic [DATA_W-1:0] data_sh;
  logic [STAT_W-1:0] stat_sh;

  rxq_pf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  rxq_pf_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .held(held), .cnt_in(int_rdata[CNT_W-1:0]),
    .int_rd(int_rd), .int_addr(int_addr), .cap_stat(cap_stat), .cap_data(cap_data)
  );

  rxq_pf_shadow #(.DATA_W(DATA_W), .CNT_W(CNT_W), .STAT_W(STAT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n_s), .cap_stat(cap_stat), .cap_data(cap_data),
    .consume(consume), .int_rdata(int_rdata), .held(held), .data_o(data_sh),
    .stat_o(stat_sh)
  );

  rxq_pf_ctrl #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .sys_rd(sys_rd), .sys_addr(sys_addr),
    .held(held), .data_i(data_sh), .stat_i(stat_sh), .consume(consume),
    .sys_rdata(sys_rdata), .sys_rvalid(sys_rvalid), .sys_uflow(sys_uflow)
  );
endmodule

// File: tb/rxq_prefetch_if_bench.sv
module rxq_prefetch_if_bench;
  localparam int DW = 8;
  localparam int QD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_rd = 1'b0;
  logic sys_addr = 1'b0;
  logic [DW-1:0] sys_rdata;
  logic sys_rvalid, sys_uflow, int_rd, int_addr;
  logic [DW-1:0] int_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // core stub state
  logic [DW-1:0] qmem [QD];
  int head = 0, tail = 0, cnt = 0, pops = 0;
  logic push_en = 1'b0;
  logic [DW-1:0] push_val = '0;

  always #5 clk = ~clk;

  rxq_prefetch_if #(.DATA_W(DW), .QDEPTH(QD)) u_rxq_prefetch_if (
    .clk(clk), .rst_n(rst_n), .sys_rd(sys_rd), .sys_addr(sys_addr),
    .sys_rdata(sys_rdata), .sys_rvalid(sys_rvalid), .sys_uflow(sys_uflow),
    .int_rd(int_rd), .int_addr(int_addr), .int_rdata(int_rdata)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_rdata <= '0;
      head = 0; tail = 0; cnt = 0; pops = 0;
    end else begin
      if (int_rd) begin
        if (int_addr) begin
          int_rdata <= qmem[head];
          if (cnt > 0) begin head = (head + 1) % QD; cnt = cnt - 1; pops = pops + 1; end
        end else begin
          int_rdata <= DW'(cnt);
        end
      end
      if (push_en && cnt < QD) begin
        qmem[tail] = push_val; tail = (tail + 1) % QD; cnt = cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic rd(input logic a, output int d, output bit uf);
    sys_rd = 1'b1; sys_addr = a;
    @(negedge clk);
    sys_rd = 1'b0;
    chk(sys_rvalid === 1'b1, "R2 response valid next cycle", int'(sys_rvalid), 1);
    d = int'(sys_rdata); uf = sys_uflow;
  endtask

  task automatic push(input logic [DW-1:0] v);
    push_en = 1'b1; push_val = v;
    @(negedge clk);
    push_en = 1'b0;
  endtask

  function automatic logic [DW-1:0] val(input int n, input int i);
    return DW'(n * 37 + i * 11 + 5);
  endfunction

  initial begin
    int d;
    bit uf;
    int consumed;
    consumed = 0;
    idle(3);
    rst_n = 1'b1;
    idle(6);
    // R1 reset state
    chk(sys_rvalid === 1'b0, "R1 valid low after reset", int'(sys_rvalid), 0);
    rd(1'b0, d, uf);
    chk(d == 0, "R1 status zero after reset", d, 0);
    rd(1'b1, d, uf);
    chk(uf == 1'b1 && d == 0, "R1 data read underflows after reset", d, 0);
    idle(1);
    chk(sys_rvalid === 1'b0, "R2 valid drops after read", int'(sys_rvalid), 0);

    for (int n = 0; n <= QD + 1; n++) begin
      for (int i = 0; i < n; i++) begin
        push(val(n, i));
        idle(8);
        rd(1'b0, d, uf);
        chk(d == i + 1, "R3 R5 status tracks pushes", d, i + 1);
      end
      // R9: burst of status reads, no side effect
      for (int k = 0; k < 3; k++) begin
        rd(1'b0, d, uf);
        chk(d == n, "R9 status burst stable", d, n);
      end
      chk(pops == consumed + (n > 0 ? 1 : 0), "R8 single prefetch pop", pops, consumed + (n > 0 ? 1 : 0));
      for (int i = 0; i < n; i++) begin
        rd(1'b1, d, uf);
        chk(uf == 1'b0 && d == int'(val(n, i)), "R4 R6 data in order", d, int'(val(n, i)));
        consumed = consumed + 1;
        rd(1'b0, d, uf);
        chk(d == n - 1 - i, "R5 status after consume", d, n - 1 - i);
        if (i == 0) begin
          rd(1'b1, d, uf);
          chk(uf == 1'b1 && d == 0, "R7 immediate reread underflows", d, 0);
          idle(8);
          rd(1'b0, d, uf);
          chk(d == n - 1, "R7 underflow loses nothing", d, n - 1);
        end
        idle(8);
        chk(pops == consumed + (i < n - 1 ? 1 : 0), "R8 pops bounded", pops, consumed + (i < n - 1 ? 1 : 0));
      end
      idle(8);
      rd(1'b0, d, uf);
      chk(d == 0, "R5 empty after drain", d, 0);
      rd(1'b1, d, uf);
      chk(uf == 1'b1 && d == 0, "R7 underflow when drained", d, 0);
      idle(8);
      chk(pops == consumed, "R7 underflow does not pop", pops, consumed);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule